// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is the programmable AND-OR plane of one logic block in a complex programmable logic device. Its inputs arrive from an upstream routing matrix. Each input is offered as a true literal and as a complement literal. A configuration memory chooses, for each product term, which literals are ANDed together. A second set of configuration bits steers each product term into any number of per-macrocell sums. All product terms come from one shared pool. A macrocell may draw up to a fixed limit of terms, and one term may feed several macrocells at once, so a common term is built only once.

Configuration enters through a one-bit serial port, one product-term row at a time. A strobe ends the load. The sums stay at 0 until a load has completed, and they also stay at 0 while a new load is in progress. The term-count limit is enforced while the rows are written. When a macrocell asks for more terms than the limit allows, the lowest-indexed terms are kept and a per-macrocell overflow flag is raised. Inputs pass through two register stages: a product-term register and a registered sum output.

Top module: `sop_array_top`

## Requirements
- R1: After reset, `sum_out` and `ovf_flags` are 0. `sum_out` stays 0 for any `in_bits` until the first `cfg_done` pulse.
- R2: Literal bit 2i of a row selects `in_bits[i]` and bit 2i+1 selects its complement. A product term is the AND of its selected literals, and a term with no literal selected is 1.
- R3: A product term that selects both literals of the same input is always 0.
- R4: Each `sum_out[m]` is the OR of the product terms steered to macrocell m. A macrocell with no steered term outputs 0.
- R5: One product term steered to several macrocells drives all of them at the same time.
- R6: When more than MAX_PT (16) terms are steered to one macrocell, only the MAX_PT lowest-indexed terms are used and `ovf_flags[m]` is set. A flag can only change while a load is in progress.
- R7: The first `cfg_shift_en` cycle of a new load clears all of `ovf_flags`.
- R8: With a completed configuration, `sum_out` reflects the `in_bits` value sampled two rising clock edges earlier.
- R9: While a load is in progress, `sum_out` is 0. New settings take effect only after `cfg_done`.
- R10: A load shifts rows for terms 0 to N_PT-1 in order, each row sent MSB first. A row is 2*N_IN+N_MC bits (88 by default): bits [2*N_IN-1:0] are the literals and bit 2*N_IN+m steers the term to macrocell m. `cfg_done` is a one-cycle pulse with `cfg_shift_en` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_bits | input | N_IN | Array inputs from the routing matrix |
| cfg_shift_en | input | 1 | Shift one configuration bit this cycle |
| cfg_sdata | input | 1 | Serial configuration bit |
| cfg_done | input | 1 | Load-complete strobe; activates the configuration |
| sum_out | output | N_MC | Registered per-macrocell sums |
| ovf_flags | output | N_MC | Per-macrocell term-limit overflow flags |

## Verification
The properties assume that every load starts with counters at a row boundary and is closed by a `cfg_done` pulse alone. They also assume that a load writes every product-term row, so the per-macrocell term counts start fresh and cover the whole pool. The stimulus keeps to this: it always shifts exactly N_PT full rows and then pulses `cfg_done` with the shift enable low. Input vectors change only between loads or while a configuration is active. Random literal and steering densities are chosen so that both overflowing and non-overflowing macrocells appear, and directed patterns cover the empty-term, contradictory-term and shared-term cases.

// File: rtl/sop_pkg.sv
package sop_pkg;

  // Configuration life cycle of the array
  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,  // nothing loaded since reset
    ST_LOAD  = 2'd1,  // rows are being shifted in
    ST_RUN   = 2'd2   // configuration complete and in effect
  } cfg_state_e;

  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader
  import sop_pkg::*;
#(
  parameter int N_LIT  = 72,
  parameter int N_PT   = 86,
  parameter int N_MC   = 16,
  parameter int MAX_PT = 16,
  localparam int ROW_W = N_LIT + N_MC,
  localparam int BIT_W = $clog2(ROW_W),
  localparam int PTR_W = $clog2(N_PT + 1),
  localparam int AW    = addr_bits(N_PT),
  localparam int CNT_W = $clog2(MAX_PT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             sdata,
  input  logic             done,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [N_LIT-1:0] wr_lit,
  output logic [N_MC-1:0]  wr_steer,
  output cfg_state_e       state,
  output logic [N_MC-1:0]  ovf_flags
);

  logic [ROW_W-2:0] row_q;
  logic [ROW_W-1:0] row_next;
  logic [BIT_W-1:0] bit_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q [N_MC];
  logic [N_MC-1:0]  want;
  logic [N_MC-1:0]  take;
  logic             shift_ok;
  logic             row_full;
  logic             start;

  assign shift_ok = shift_en && !done;
  assign row_next = {row_q, sdata};
  assign row_full = shift_ok && (bit_q == BIT_W'(ROW_W - 1));
  assign start    = shift_ok && (state != ST_LOAD);
  assign want     = row_next[ROW_W-1 -: N_MC];

  // Term-limit enforcement: a steering bit survives only while the
  // macrocell is below its limit, so lower term indices win.
  for (genvar m = 0; m < N_MC; m++) begin : g_cap
    assign take[m] = want[m] && (cnt_q[m] < CNT_W'(MAX_PT));
  end

  assign wr_en    = row_full && (ptr_q < PTR_W'(N_PT));
  assign wr_addr  = AW'(ptr_q);
  assign wr_lit   = row_next[N_LIT-1:0];
  assign wr_steer = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_BLANK;
      row_q     <= '0;
      bit_q     <= '0;
      ptr_q     <= '0;
      ovf_flags <= '0;
      for (int m = 0; m < N_MC; m++) cnt_q[m] <= '0;
    end else if (done) begin
      state <= ST_RUN;
      bit_q <= '0;
      ptr_q <= '0;
    end else if (shift_ok) begin
      row_q <= row_next[ROW_W-2:0];
      if (start) begin
        state     <= ST_LOAD;
        ovf_flags <= '0;
        for (int m = 0; m < N_MC; m++) cnt_q[m] <= '0;
      end
      if (row_full) begin
        bit_q <= '0;
        if (wr_en) begin
          ptr_q <= ptr_q + PTR_W'(1);
          for (int m = 0; m < N_MC; m++) begin
            if (take[m]) cnt_q[m] <= cnt_q[m] + CNT_W'(1);
            if (want[m] && !take[m]) ovf_flags[m] <= 1'b1;
          end
        end
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sop_term_plane.sv
module sop_term_plane
  import sop_pkg::*;
#(
  parameter int N_IN = 36,
  parameter int N_PT = 86,
  parameter int N_MC = 16,
  localparam int N_LIT = 2 * N_IN,
  localparam int AW    = addr_bits(N_PT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [N_LIT-1:0]     wr_lit,
  input  logic [N_MC-1:0]      wr_steer,
  input  logic [N_IN-1:0]      in_bits,
  output logic [N_PT-1:0]      pt_q,
  output logic [N_PT*N_MC-1:0] steer_flat
);

  logic [N_LIT-1:0] lit_mem   [N_PT];
  logic [N_MC-1:0]  steer_mem [N_PT];
  logic [N_LIT-1:0] lits;
  logic [N_PT-1:0]  pt_d;

  // One row per product term, one write port, no reset on the storage
  always_ff @(posedge clk) begin
    if (wr_en) begin
      lit_mem[wr_addr]   <= wr_lit;
      steer_mem[wr_addr] <= wr_steer;
    end
  end

  // Even column = true literal, odd column = complement
  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_bits[i];
    assign lits[2*i+1] = ~in_bits[i];
  end

  // Unselected columns are forced high, so an empty row yields 1
  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pt_d[t]                   = &(lits | ~lit_mem[t]);
    assign steer_flat[t*N_MC +: N_MC] = steer_mem[t];
  end

  always_ff @(posedge clk) begin
    if (rst) pt_q <= '0;
    else     pt_q <= pt_d;
  end

endmodule

// File: rtl/sop_sum_plane.sv
module sop_sum_plane #(
  parameter int N_PT = 86,
  parameter int N_MC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic [N_PT-1:0]      pt_q,
  input  logic [N_PT*N_MC-1:0] steer_flat,
  output logic [N_MC-1:0]      sum_out
);

  logic [N_MC-1:0] sum_d;

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    logic [N_PT-1:0] col;
    for (genvar t = 0; t < N_PT; t++) begin : g_col
      assign col[t] = steer_flat[t*N_MC + m];
    end
    assign sum_d[m] = |(pt_q & col);
  end

  always_ff @(posedge clk) begin
    if (rst)          sum_out <= '0;
    else if (active)  sum_out <= sum_d;
    else              sum_out <= '0;
  end

endmodule

// File: rtl/sop_array_top.sv
module sop_array_top
  import sop_pkg::*;
#(
  parameter int N_IN   = 36,
  parameter int N_PT   = 86,
  parameter int N_MC   = 16,
  parameter int MAX_PT = 16,
  localparam int N_LIT = 2 * N_IN,
  localparam int AW    = addr_bits(N_PT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] in_bits,
  input  logic            cfg_shift_en,
  input  logic            cfg_sdata,
  input  logic            cfg_done,
  output logic [N_MC-1:0] sum_out,
  output logic [N_MC-1:0] ovf_flags
);

  logic                 wr_en;
  logic [AW-1:0]        wr_addr;
  logic [N_LIT-1:0]     wr_lit;
  logic [N_MC-1:0]      wr_steer;
  cfg_state_e           cfg_state;
  logic [N_PT-1:0]      pt_q;
  logic [N_PT*N_MC-1:0] steer_flat;

  sop_cfg_loader #(
    .N_LIT(N_LIT), .N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT)
  ) loader_i (
    .clk(clk), .rst(rst),
    .shift_en(cfg_shift_en), .sdata(cfg_sdata), .done(cfg_done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lit(wr_lit), .wr_steer(wr_steer),
    .state(cfg_state), .ovf_flags(ovf_flags)
  );

  sop_term_plane #(
    .N_IN(N_IN), .N_PT(N_PT), .N_MC(N_MC)
  ) terms_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lit(wr_lit), .wr_steer(wr_steer),
    .in_bits(in_bits), .pt_q(pt_q), .steer_flat(steer_flat)
  );

  sop_sum_plane #(
    .N_PT(N_PT), .N_MC(N_MC)
  ) sums_i (
    .clk(clk), .rst(rst),
    .active(cfg_state == ST_RUN),
    .pt_q(pt_q), .steer_flat(steer_flat), .sum_out(sum_out)
  );

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
  import sop_pkg::*;
#(
  parameter int N_MC = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_shift_en,
  input logic            cfg_done,
  input logic [N_MC-1:0] sum_out,
  input logic [N_MC-1:0] ovf_flags,
  input cfg_state_e      state
);

  // R1
  blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_BLANK |=> sum_out == '0);

  // R9
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOAD |=> sum_out == '0);

  // R10
  done_commit_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> state == ST_RUN);

  // R7
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_LOAD && cfg_shift_en && !cfg_done) |=> (ovf_flags == '0 && state == ST_LOAD));

  // R6
  ovf_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ovf_flags & ~$past(ovf_flags))) |-> $past(state) == ST_LOAD);

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !cfg_shift_en) |=> $stable(ovf_flags));

endmodule

bind sop_array_top sop_array_chk #(.N_MC(N_MC)) chk_i (
  .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_done(cfg_done),
  .sum_out(sum_out), .ovf_flags(ovf_flags), .state(cfg_state)
);

// File: tb/sop_array_top_tb_top.sv
module sop_array_top_tb_top;

  localparam int N_IN   = 36;
  localparam int N_PT   = 86;
  localparam int N_MC   = 16;
  localparam int MAX_PT = 16;
  localparam int N_LIT  = 2 * N_IN;
  localparam int ROW_W  = N_LIT + N_MC;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst;
  logic [N_IN-1:0] in_bits;
  logic            cfg_shift_en, cfg_sdata, cfg_done;
  logic [N_MC-1:0] sum_out, ovf_flags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [N_LIT-1:0] m_lit   [N_PT];
  logic [N_MC-1:0]  m_steer [N_PT];

  sop_array_top #(.N_IN(N_IN), .N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT)) dut_i (
    .clk(clk), .rst(rst), .in_bits(in_bits),
    .cfg_shift_en(cfg_shift_en), .cfg_sdata(cfg_sdata), .cfg_done(cfg_done),
    .sum_out(sum_out), .ovf_flags(ovf_flags)
  );

  function automatic logic [N_MC-1:0] exp_sum(input logic [N_IN-1:0] v);
    logic [N_PT-1:0] pt;
    logic [N_MC-1:0] s;
    int cnt;
    for (int t = 0; t < N_PT; t++) begin
      pt[t] = 1'b1;
      for (int j = 0; j < N_LIT; j++)
        if (m_lit[t][j] && ((j % 2 == 0) ? !v[j/2] : v[j/2])) pt[t] = 1'b0;
    end
    s = '0;
    for (int m = 0; m < N_MC; m++) begin
      cnt = 0;
      for (int t = 0; t < N_PT; t++)
        if (m_steer[t][m]) begin
          if (cnt < MAX_PT) s[m] = s[m] | pt[t];
          cnt++;
        end
    end
    return s;
  endfunction

  function automatic logic [N_MC-1:0] exp_ovf();
    logic [N_MC-1:0] f;
    int cnt;
    f = '0;
    for (int m = 0; m < N_MC; m++) begin
      cnt = 0;
      for (int t = 0; t < N_PT; t++) if (m_steer[t][m]) cnt++;
      f[m] = (cnt > MAX_PT);
    end
    return f;
  endfunction

  function automatic logic [N_IN-1:0] rand_vec();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[N_IN-1:0];
  endfunction

  task automatic check(input string tag, input logic [N_MC-1:0] act, input logic [N_MC-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < N_PT; t++) begin
      m_lit[t]   = '0;
      m_steer[t] = '0;
    end
  endtask

  task automatic rand_model(input int t_lo, input int mc_lo, input int steer_div);
    for (int t = t_lo; t < N_PT; t++) begin
      int k;
      m_lit[t]   = '0;
      m_steer[t] = '0;
      k = $urandom_range(3, 0);
      for (int i = 0; i < k; i++) m_lit[t][$urandom_range(N_LIT - 1, 0)] = 1'b1;
      for (int m = mc_lo; m < N_MC; m++)
        m_steer[t][m] = ($urandom_range(steer_div - 1, 0) == 0);
    end
  endtask

  // Shifts all rows MSB first, term 0 first, then pulses the done strobe
  task automatic load_model();
    for (int t = 0; t < N_PT; t++) begin
      logic [ROW_W-1:0] row;
      row = {m_steer[t], m_lit[t]};
      for (int b = ROW_W - 1; b >= 0; b--) begin
        @(negedge clk);
        if (t == 0 && b == ROW_W - 2)
          check("R7 flags cleared on first shift", ovf_flags, '0);
        if (t == 40 && b == 0)
          check("R9 sums held during load", sum_out, '0);
        cfg_shift_en = 1'b1;
        cfg_sdata    = row[b];
      end
    end
    @(negedge clk);
    cfg_shift_en = 1'b0;
    cfg_done     = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic apply_vec(input logic [N_IN-1:0] v, input string tag);
    @(negedge clk);
    in_bits = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(tag, sum_out, exp_sum(v));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N_IN-1:0] va, vb;
    void'($urandom(32'h5eed_0a11));
    rst = 1'b1;
    in_bits = '0;
    cfg_shift_en = 1'b0;
    cfg_sdata = 1'b0;
    cfg_done = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: nothing loaded yet, outputs stay low for any input
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_bits = rand_vec();
      repeat (2) @(negedge clk);
      check("R1 sums before first load", sum_out, '0);
      check("R1 flags after reset", ovf_flags, '0);
    end

    // Directed configuration with random filler on the upper macrocells
    clear_model();
    m_steer[0][0] = 1'b1;                      // empty term
    m_lit[1][0] = 1'b1; m_lit[1][1] = 1'b1;    // in0 and ~in0
    m_steer[1][1] = 1'b1;
    m_lit[2][6] = 1'b1; m_lit[2][11] = 1'b1;   // in3 & ~in5
    m_steer[2][3] = 1'b1; m_steer[2][4] = 1'b1; m_steer[2][6] = 1'b1;
    m_lit[3][14] = 1'b1;                       // in7
    m_steer[3][6] = 1'b1;
    rand_model(4, 7, 8);
    load_model();

    apply_vec('0, "R2 all-zero input");
    check("R2 empty term is one", {15'b0, sum_out[0]}, 16'd1);
    check("R4 macrocell without terms", {15'b0, sum_out[2]}, 16'd0);
    va = rand_vec(); va[3] = 1'b1; va[5] = 1'b0; va[0] = 1'b1; va[7] = 1'b0;
    apply_vec(va, "R5 shared term high");
    check("R5 shared term on two sums", {14'b0, sum_out[4:3]}, 16'd3);
    check("R3 contradictory term", {15'b0, sum_out[1]}, 16'd0);
    check("R4 OR of two terms", {15'b0, sum_out[6]}, 16'd1);
    vb = va; vb[3] = 1'b0; vb[7] = 1'b0;
    apply_vec(vb, "R5 shared term low");
    check("R5 shared term low on both", {14'b0, sum_out[4:3]}, 16'd0);

    // R8: one edge after the change the old result remains, two edges the new
    apply_vec(va, "R8 settle");
    @(negedge clk);
    in_bits = vb;
    @(negedge clk);
    check("R8 after one edge", sum_out, exp_sum(va));
    @(negedge clk);
    check("R8 after two edges", sum_out, exp_sum(vb));

    for (int i = 0; i < 20; i++) apply_vec(rand_vec(), "R4 random vector");
    check("R6 no overflow expected", ovf_flags, exp_ovf());

    // Overflow: sixteen always-zero terms then four always-one terms on mc5
    clear_model();
    for (int t = 0; t < 20; t++) m_steer[t][5] = 1'b1;
    for (int t = 0; t < 16; t++) begin
      m_lit[t][2*t] = 1'b1;
      m_lit[t][2*t+1] = 1'b1;
    end
    m_steer[20][0] = 1'b1;
    load_model();
    check("R6 overflow flag", ovf_flags, exp_ovf());
    check("R6 overflow flag on mc5", ovf_flags, 16'h0020);
    for (int i = 0; i < 5; i++) apply_vec(rand_vec(), "R6 capped sum");
    check("R6 extra terms dropped", {15'b0, sum_out[5]}, 16'd0);

    // Random sparse configuration: also exercises R7 and R9 inside the load
    rand_model(0, 0, 16);
    load_model();
    check("R7 flags after new load", ovf_flags, exp_ovf());
    for (int i = 0; i < 30; i++) apply_vec(rand_vec(), "R10 serial row format");

    // Random dense steering: overflow on many macrocells
    rand_model(0, 0, 4);
    load_model();
    check("R6 dense overflow flags", ovf_flags, exp_ovf());
    for (int i = 0; i < 20; i++) apply_vec(rand_vec(), "R6 dense capped sums");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule